// File: doc/BRIEF.md
# Command Legality and Mode Code Dispatcher

This block sits behind the word decoder of a remote terminal on a dual-redundant 1553 bus. For each validated command word addressed to the terminal, it decides whether the command is a subaddress transfer or a mode command, and whether it is legal. It then drives the sequencing flags that the message controller follows: store the command word, store the data, send one data word, send the previous command word, and send or suppress the status word.

Legality comes from three sources:
- reserved subaddress sets that depend on a legacy/current rule selector and on the transfer direction;
- a fixed table of defined mode codes;
- the host's illegal-command input, sampled over a short window after the command arrives.

The block also holds the persistent state that mode commands change: one transmit enable per bus, the terminal-flag enable, the status-word message-error bit and the last stored command word.

Top module: `cmd_legality_disp`

## Requirements
- R1: After reset, res_vld=0, me_bit=0, prev_cmd=0, tx_en=2'b11 (bit 0 bus A, bit 1 bus B) and tf_en=1.
- R2: A command pulse is taken only when bits 15:11 of cmd_word equal own_addr, or equal 31 while bcast_en=1. Address 31 with bcast_en=0 is taken only if own_addr is 31. Any other pulse produces no result.
- R3: ill_in is sampled on the accepting edge and on the ILL_WIN (default 2) edges that follow. res_vld is high for exactly one cycle after the last sampling edge. A pulse that arrives while a command is pending is ignored.
- R4: A subaddress field (bits 9:5) of 0 or 31 marks a mode command: is_sa=0 and mcsa=bits 4:0. Otherwise is_sa=1 and mcsa=the subaddress. Bit 10 is the direction (1 = transmit).
- R5: With notice3_sel=0, receive subaddresses 1, 3, 5, 8, 11, 14, 15, 19, 21 and 27 are reserved, and transmit subaddresses 3, 5, 8, 11, 14, 19 and 27 are reserved.
- R6: With notice3_sel=1, subaddress 8 is the only reserved subaddress, in both directions.
- R7: The defined mode codes are transmit 1, 2, 3, 4, 5, 6, 7, 8, 16, 18 and 19, and receive 17. Every other direction/code pair, including transmit 0, receive 20 and receive 21, is reserved.
- R8: A reserved subaddress, a reserved mode code or a sampled ill_in sets msg_err. msg_err blocks store_data, send_data and any mode action, but status_en stays 1 for a non-broadcast command.
- R9: Mode code 4 (transmitter shutdown) clears the tx_en bit of the bus other than cmd_chan. Mode code 5 (override) sets that bit again.
- R10: Mode code 6 clears tf_en, and tf_bit = host_tf AND tf_en. Mode code 7 sets tf_en without forcing tf_bit high.
- R11: Transmit mode code 18 gives send_last=1 and store_cmd=0. It leaves me_bit and prev_cmd unchanged. Every other result loads me_bit with msg_err and loads prev_cmd with the command word.
- R12: Legal transmit mode codes 16 and 19 give send_data=1. Legal receive mode code 17 gives store_data=1. A legal receive subaddress gives store_data=1, and a legal transmit subaddress gives send_data=1.
- R13: A command to address 31 with bcast_en=1 gives bcast=1, status_en=0, send_data=0 and send_last=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | One-cycle strobe: cmd_word holds a validated command |
| cmd_word | input | 16 | Command word (address, direction, subaddress, count/code) |
| cmd_chan | input | 1 | Bus the command came in on (0 = A, 1 = B) |
| own_addr | input | 5 | Terminal address |
| notice3_sel | input | 1 | 1 selects current reserved-subaddress rule, 0 the legacy rule |
| bcast_en | input | 1 | Enables broadcast recognition of address 31 |
| ill_in | input | 1 | Host illegal-command request |
| host_tf | input | 1 | Host terminal-flag request |
| res_vld | output | 1 | One-cycle pulse: result fields valid |
| msg_err | output | 1 | Command judged illegal |
| me_bit | output | 1 | Message-error bit for the status word |
| is_sa | output | 1 | 1 = subaddress command, 0 = mode command |
| mcsa | output | 5 | Subaddress or mode code |
| bcast | output | 1 | Command was a broadcast |
| status_en | output | 1 | Status word is to be sent |
| store_cmd | output | 1 | Command word is to be stored |
| store_data | output | 1 | Received data words are to be stored |
| send_data | output | 1 | Data word(s) are to be transmitted |
| send_last | output | 1 | Previous command word is to be transmitted |
| prev_cmd | output | 16 | Last stored command word |
| tx_en | output | 2 | Transmit enables, bit 0 bus A, bit 1 bus B |
| tf_en | output | 1 | Terminal-flag enable |
| tf_bit | output | 1 | Terminal flag for the status word |

## Verification
Two of the block's judgements can collide on a single result:
- a host illegal-command request landing on a command that is also a state-changing or reserved mode code;
- a transmit-last-command request landing on a held message-error bit.

The bench provokes the first by raising ill_in over the window of a shutdown command, and by raising it only on the final sampling edge. It judges the outcome by checking that tx_en keeps its value while msg_err is set. It provokes the second by following an illegal receive command with mode code 18, and then checks that me_bit still reads 1 while send_last is high and store_cmd is low.

// File: rtl/cmdc_pkg.sv
package cmdc_pkg;

   localparam int ADDR_W  = 5;
   localparam int SUB_W   = 5;
   localparam int CODE_W  = 5;
   localparam int WORD_W  = ADDR_W + 1 + SUB_W + CODE_W;
   localparam int N_SUB   = 1 << SUB_W;

   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic              tr;
      logic [SUB_W-1:0]  sub;
      logic [CODE_W-1:0] cnt;
   } cmd_word_t;

   typedef struct packed {
      logic legal;
      logic rx_word;
      logic tx_word;
      logic last_cmd;
      logic tx_off;
      logic tx_on;
      logic tf_off;
      logic tf_on;
   } mc_act_t;

   localparam logic [SUB_W-1:0] SUB_MODE_LO = '0;
   localparam logic [SUB_W-1:0] SUB_MODE_HI = '1;

endpackage

// File: rtl/cmdc_sub_screen.sv
module cmdc_sub_screen
   import cmdc_pkg::*;
#(
   parameter int                 RULE_SEL     = 0,
   parameter logic [N_SUB-1:0]   RSV_RX_LEG   = 32'h0828_C92A,
   parameter logic [N_SUB-1:0]   RSV_TX_LEG   = 32'h0808_4928,
   parameter logic [N_SUB-1:0]   RSV_CUR      = 32'h0000_0100
) (
   input  logic             cur_rule,
   input  logic             tr,
   input  logic [SUB_W-1:0] sub,
   output logic             reserved
);

   logic leg_hit;
   logic cur_hit;

   assign leg_hit = tr ? RSV_TX_LEG[sub] : RSV_RX_LEG[sub];
   assign cur_hit = RSV_CUR[sub];

   generate
      if (RULE_SEL == 0) begin : g_runtime
         assign reserved = cur_rule ? cur_hit : leg_hit;
      end else if (RULE_SEL == 1) begin : g_legacy
         logic unused_sel;
         assign unused_sel = cur_rule;
         assign reserved   = leg_hit;
      end else begin : g_current
         logic unused_sel;
         assign unused_sel = cur_rule;
         assign reserved   = cur_hit;
      end
      if (RULE_SEL < 0 || RULE_SEL > 2) begin : g_bad_rule
         $error("cmdc_sub_screen: RULE_SEL must be 0, 1 or 2");
      end
   endgenerate

endmodule

// File: rtl/cmdc_mode_decode.sv
module cmdc_mode_decode
   import cmdc_pkg::*;
(
   input  logic              tr,
   input  logic [CODE_W-1:0] code,
   output mc_act_t           act
);

   always_comb begin
      act = '0;
      unique case ({tr, code})
         {1'b1, 5'd1},
         {1'b1, 5'd2},
         {1'b1, 5'd3},
         {1'b1, 5'd8}:  act.legal = 1'b1;
         {1'b1, 5'd4}:  begin act.legal = 1'b1; act.tx_off   = 1'b1; end
         {1'b1, 5'd5}:  begin act.legal = 1'b1; act.tx_on    = 1'b1; end
         {1'b1, 5'd6}:  begin act.legal = 1'b1; act.tf_off   = 1'b1; end
         {1'b1, 5'd7}:  begin act.legal = 1'b1; act.tf_on    = 1'b1; end
         {1'b1, 5'd16},
         {1'b1, 5'd19}: begin act.legal = 1'b1; act.tx_word  = 1'b1; end
         {1'b1, 5'd18}: begin act.legal = 1'b1; act.last_cmd = 1'b1; end
         {1'b0, 5'd17}: begin act.legal = 1'b1; act.rx_word  = 1'b1; end
         default:       act = '0;
      endcase
   end

endmodule

// File: rtl/cmdc_ill_window.sv
module cmdc_ill_window #(
   parameter int ILL_WIN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic ill_in,
   output logic busy,
   output logic done,
   output logic ill_all
);

   localparam int CNT_W = (ILL_WIN < 2) ? 1 : $clog2(ILL_WIN);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ILL_WIN - 1);

   logic [CNT_W-1:0] cnt;
   logic             acc;

   generate
      if (ILL_WIN < 1) begin : g_bad_win
         $error("cmdc_ill_window: ILL_WIN must be at least 1");
      end
   endgenerate

   assign done    = busy && (cnt == LAST);
   assign ill_all = acc | ill_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         acc  <= 1'b0;
      end else if (!busy) begin
         if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
            acc  <= ill_in;
         end
      end else if (done) begin
         busy <= 1'b0;
         cnt  <= '0;
         acc  <= 1'b0;
      end else begin
         cnt <= cnt + 1'b1;
         acc <= acc | ill_in;
      end
   end

   a_r3_one_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r3_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

endmodule

// File: rtl/cmd_legality_disp.sv
module cmd_legality_disp
   import cmdc_pkg::*;
#(
   parameter int               ILL_WIN    = 2,
   parameter int               RULE_SEL   = 0,
   parameter logic [ADDR_W-1:0] BCAST_ADDR = 5'd31,
   parameter logic [N_SUB-1:0] RSV_RX_LEG = 32'h0828_C92A,
   parameter logic [N_SUB-1:0] RSV_TX_LEG = 32'h0808_4928,
   parameter logic [N_SUB-1:0] RSV_CUR    = 32'h0000_0100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_vld,
   input  logic [15:0]       cmd_word,
   input  logic              cmd_chan,
   input  logic [4:0]        own_addr,
   input  logic              notice3_sel,
   input  logic              bcast_en,
   input  logic              ill_in,
   input  logic              host_tf,
   output logic              res_vld,
   output logic              msg_err,
   output logic              me_bit,
   output logic              is_sa,
   output logic [4:0]        mcsa,
   output logic              bcast,
   output logic              status_en,
   output logic              store_cmd,
   output logic              store_data,
   output logic              send_data,
   output logic              send_last,
   output logic [15:0]       prev_cmd,
   output logic [1:0]        tx_en,
   output logic              tf_en,
   output logic              tf_bit
);

   generate
      if (WORD_W != 16) begin : g_bad_word
         $error("cmd_legality_disp: command word layout must total 16 bits");
      end
   endgenerate

   cmd_word_t in_w;
   cmd_word_t cw_q;
   logic      chan_q;
   logic      bc_q;
   logic      hit_own;
   logic      hit_bc;
   logic      start;
   logic      busy;
   logic      done;
   logic      ill_all;

   assign in_w    = cmd_word_t'(cmd_word);
   assign hit_own = (in_w.addr == own_addr);
   assign hit_bc  = bcast_en && (in_w.addr == BCAST_ADDR);
   assign start   = cmd_vld && (hit_own || hit_bc);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cw_q   <= '0;
         chan_q <= 1'b0;
         bc_q   <= 1'b0;
      end else if (start && !busy) begin
         cw_q   <= in_w;
         chan_q <= cmd_chan;
         bc_q   <= hit_bc;
      end
   end

   cmdc_ill_window #(.ILL_WIN(ILL_WIN)) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .ill_in  (ill_in),
      .busy    (busy),
      .done    (done),
      .ill_all (ill_all)
   );

   logic    sub_rsv;
   mc_act_t mc;

   cmdc_sub_screen #(
      .RULE_SEL   (RULE_SEL),
      .RSV_RX_LEG (RSV_RX_LEG),
      .RSV_TX_LEG (RSV_TX_LEG),
      .RSV_CUR    (RSV_CUR)
   ) u_screen (
      .cur_rule (notice3_sel),
      .tr       (cw_q.tr),
      .sub      (cw_q.sub),
      .reserved (sub_rsv)
   );

   cmdc_mode_decode u_mode (
      .tr   (cw_q.tr),
      .code (cw_q.cnt),
      .act  (mc)
   );

   logic mode_c;
   logic err_c;
   logic act_c;
   logic keep_c;
   logic rxd_c;
   logic txd_c;
   logic lst_c;

   always_comb begin
      mode_c = (cw_q.sub == SUB_MODE_LO) || (cw_q.sub == SUB_MODE_HI);
      err_c  = ill_all || (mode_c ? !mc.legal : sub_rsv);
      act_c  = mode_c && mc.legal && !ill_all;
      keep_c = mode_c && mc.last_cmd;
      rxd_c  = !err_c && (mode_c ? mc.rx_word : !cw_q.tr);
      txd_c  = !err_c && !bc_q && (mode_c ? mc.tx_word : cw_q.tr);
      lst_c  = act_c && mc.last_cmd && !bc_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_vld    <= 1'b0;
         msg_err    <= 1'b0;
         is_sa      <= 1'b0;
         mcsa       <= '0;
         bcast      <= 1'b0;
         status_en  <= 1'b0;
         store_cmd  <= 1'b0;
         store_data <= 1'b0;
         send_data  <= 1'b0;
         send_last  <= 1'b0;
      end else begin
         res_vld <= done;
         if (done) begin
            msg_err    <= err_c;
            is_sa      <= !mode_c;
            mcsa       <= mode_c ? cw_q.cnt : cw_q.sub;
            bcast      <= bc_q;
            status_en  <= !bc_q;
            store_cmd  <= !keep_c;
            store_data <= rxd_c;
            send_data  <= txd_c;
            send_last  <= lst_c;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         me_bit   <= 1'b0;
         prev_cmd <= '0;
      end else if (done && !keep_c) begin
         me_bit   <= err_c;
         prev_cmd <= cw_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_en <= 2'b11;
         tf_en <= 1'b1;
      end else if (done && act_c) begin
         if (mc.tx_off) tx_en[!chan_q] <= 1'b0;
         if (mc.tx_on)  tx_en[!chan_q] <= 1'b1;
         if (mc.tf_off) tf_en <= 1'b0;
         if (mc.tf_on)  tf_en <= 1'b1;
      end
   end

   assign tf_bit = host_tf && tf_en;

   a_r11_last_holds_me: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && send_last) |-> (me_bit == $past(me_bit) && !store_cmd));
   a_r13_bcast_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && bcast) |-> (!status_en && !send_data && !send_last));
   a_r8_err_blocks_data: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && msg_err) |-> (!store_data && !send_data));
   a_r9_txen_on_mode: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tx_en) |-> (res_vld && !is_sa && !msg_err));
   a_r10_tfen_on_mode: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tf_en) |-> (res_vld && !is_sa && !msg_err));

endmodule

// File: tb/tb_cmd_legality_disp.sv
module tb_cmd_legality_disp;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cmd_vld;
   logic [15:0] cmd_word;
   logic        cmd_chan;
   logic [4:0]  own_addr;
   logic        notice3_sel;
   logic        bcast_en;
   logic        ill_in;
   logic        host_tf;
   logic        res_vld, msg_err, me_bit, is_sa, bcast, status_en;
   logic        store_cmd, store_data, send_data, send_last, tf_en, tf_bit;
   logic [4:0]  mcsa;
   logic [15:0] prev_cmd;
   logic [1:0]  tx_en;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   cmd_legality_disp dut (
      .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_word(cmd_word),
      .cmd_chan(cmd_chan), .own_addr(own_addr), .notice3_sel(notice3_sel),
      .bcast_en(bcast_en), .ill_in(ill_in), .host_tf(host_tf),
      .res_vld(res_vld), .msg_err(msg_err), .me_bit(me_bit), .is_sa(is_sa),
      .mcsa(mcsa), .bcast(bcast), .status_en(status_en), .store_cmd(store_cmd),
      .store_data(store_data), .send_data(send_data), .send_last(send_last),
      .prev_cmd(prev_cmd), .tx_en(tx_en), .tf_en(tf_en), .tf_bit(tf_bit)
   );

   // {rule3, bcast_en, ill, chan, word, exp{res,err,sa,scmd,sdat,sndd,last,stat,bc}, mcsa}
   localparam int NV = 28;
   localparam logic [33:0] VEC [0:NV-1] = '{
      {4'b1100, 16'h2882, 9'b101110010, 5'd4},   // R4 R12 rx sub 4
      {4'b1100, 16'h2C41, 9'b101101010, 5'd2},   // R12 tx sub 2
      {4'b1100, 16'h2900, 9'b111100010, 5'd8},   // R6 rx sub 8 reserved
      {4'b1100, 16'h2820, 9'b101110010, 5'd1},   // R6 rx sub 1 legal
      {4'b0100, 16'h2820, 9'b111100010, 5'd1},   // R5 rx sub 1 reserved
      {4'b0100, 16'h2C20, 9'b101101010, 5'd1},   // R5 tx sub 1 legal
      {4'b0100, 16'h29E0, 9'b111100010, 5'd15},  // R5 rx sub 15
      {4'b0100, 16'h2DE0, 9'b101101010, 5'd15},  // R5 tx sub 15
      {4'b0100, 16'h2F60, 9'b111100010, 5'd27},  // R5 tx sub 27
      {4'b1100, 16'h2F60, 9'b101101010, 5'd27},  // R6 tx sub 27
      {4'b0100, 16'h2AA0, 9'b111100010, 5'd21},  // R5 rx sub 21
      {4'b1100, 16'h2C02, 9'b100100010, 5'd2},   // R7 tx status word
      {4'b1100, 16'h2FF0, 9'b100101010, 5'd16},  // R12 vector, sub 31
      {4'b1100, 16'h2C13, 9'b100101010, 5'd19},  // R12 BIT word
      {4'b1100, 16'h2811, 9'b100110010, 5'd17},  // R12 sync with data
      {4'b1100, 16'h2C00, 9'b110100010, 5'd0},   // R7 dynamic bus control
      {4'b1100, 16'h2814, 9'b110100010, 5'd20},  // R7 rx 20
      {4'b1100, 16'h2BF5, 9'b110100010, 5'd21},  // R7 rx 21 sub 31
      {4'b1100, 16'h2C09, 9'b110100010, 5'd9},   // R7 undefined tx 9
      {4'b1100, 16'h2801, 9'b110100010, 5'd1},   // R7 undefined rx 1
      {4'b1110, 16'h2882, 9'b111100010, 5'd4},   // R8 host illegal rx
      {4'b1110, 16'h2C41, 9'b111100010, 5'd2},   // R8 host illegal tx
      {4'b1110, 16'h2811, 9'b110100010, 5'd17},  // R8 host illegal sync data
      {4'b1101, 16'hF882, 9'b101110001, 5'd4},   // R13 broadcast rx
      {4'b1100, 16'hFC41, 9'b101100001, 5'd2},   // R13 broadcast tx
      {4'b0100, 16'h2C02, 9'b100100010, 5'd2},   // R7 mode under legacy rule
      {4'b1100, 16'h3082, 9'b000000000, 5'd0},   // R2 other address
      {4'b1000, 16'hF882, 9'b000000000, 5'd0}    // R2 addr 31, broadcast off
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // drive at negedge; sample after the last window edge
   task automatic send(input logic [15:0] w, input logic ch, input logic il);
      @(negedge clk);
      cmd_word = w; cmd_chan = ch; ill_in = il; cmd_vld = 1'b1;
      @(negedge clk);
      cmd_vld = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cmd_vld = 1'b0; cmd_word = '0; cmd_chan = 1'b0;
      own_addr = 5'd5; notice3_sel = 1'b1; bcast_en = 1'b1;
      ill_in = 1'b0; host_tf = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 res_vld", res_vld, 0);
      chk("R1 me_bit", me_bit, 0);
      chk("R1 prev_cmd", prev_cmd, 0);
      chk("R1 tx_en", tx_en, 2'b11);
      chk("R1 tf_en", tf_en, 1);
      chk("R1 tf_bit", tf_bit, 1);

      for (int i = 0; i < NV; i++) begin
         logic [33:0] v;
         v = VEC[i];
         notice3_sel = v[33];
         bcast_en    = v[32];
         send(v[29:14], v[30], v[31]);
         chk($sformatf("R2 R3 v%0d res_vld", i), res_vld, v[13]);
         if (v[13]) begin
            chk($sformatf("R5 R6 R7 R8 v%0d msg_err", i), msg_err, v[12]);
            chk($sformatf("R4 v%0d is_sa", i), is_sa, v[11]);
            chk($sformatf("R11 v%0d store_cmd", i), store_cmd, v[10]);
            chk($sformatf("R12 v%0d store_data", i), store_data, v[9]);
            chk($sformatf("R12 v%0d send_data", i), send_data, v[8]);
            chk($sformatf("R11 v%0d send_last", i), send_last, v[7]);
            chk($sformatf("R13 v%0d status_en", i), status_en, v[6]);
            chk($sformatf("R13 v%0d bcast", i), bcast, v[5]);
            chk($sformatf("R4 v%0d mcsa", i), mcsa, v[4:0]);
            chk($sformatf("R11 v%0d me_bit", i), me_bit, v[12]);
            chk($sformatf("R11 v%0d prev_cmd", i), prev_cmd, v[29:14]);
         end
         ill_in = 1'b0;
      end
      notice3_sel = 1'b1; bcast_en = 1'b1;

      // R9 shutdown and override of the alternate bus
      send(16'h2C04, 1'b0, 1'b0);
      chk("R9 shutdown from A", tx_en, 2'b01);
      send(16'h2C05, 1'b1, 1'b1);
      chk("R8 illegal override blocked", tx_en, 2'b01);
      chk("R8 illegal override msg_err", msg_err, 1);
      send(16'h2C05, 1'b0, 1'b0);
      chk("R9 override from A", tx_en, 2'b11);
      send(16'h2C04, 1'b1, 1'b0);
      chk("R9 shutdown from B", tx_en, 2'b10);
      send(16'h2C05, 1'b1, 1'b0);
      chk("R9 override from B", tx_en, 2'b11);

      // R8 ill only on the final sampling edge still counts
      @(negedge clk);
      cmd_word = 16'h2C04; cmd_chan = 1'b0; ill_in = 1'b0; cmd_vld = 1'b1;
      @(negedge clk); cmd_vld = 1'b0;
      @(negedge clk); ill_in = 1'b1;
      @(negedge clk); ill_in = 1'b0;
      chk("R8 late ill msg_err", msg_err, 1);
      chk("R8 late ill no shutdown", tx_en, 2'b11);
      chk("R3 result pulse", res_vld, 1);
      @(negedge clk);
      chk("R3 pulse ends", res_vld, 0);

      // R10 terminal flag inhibit / override
      host_tf = 1'b1;
      send(16'h2C06, 1'b0, 1'b0);
      chk("R10 inhibit tf_en", tf_en, 0);
      chk("R10 inhibit tf_bit", tf_bit, 0);
      host_tf = 1'b0;
      send(16'h2C07, 1'b0, 1'b0);
      chk("R10 override tf_en", tf_en, 1);
      chk("R10 override not set", tf_bit, 0);
      host_tf = 1'b1;
      #1;
      chk("R10 flag follows host", tf_bit, 1);

      // R11 transmit last command keeps me_bit and prev_cmd
      send(16'h2882, 1'b0, 1'b1);
      chk("R11 setup me_bit", me_bit, 1);
      send(16'h2C12, 1'b0, 1'b0);
      chk("R11 send_last", send_last, 1);
      chk("R11 store_cmd", store_cmd, 0);
      chk("R11 msg_err", msg_err, 0);
      chk("R11 me_bit held", me_bit, 1);
      chk("R11 prev_cmd held", prev_cmd, 16'h2882);
      chk("R11 status_en", status_en, 1);
      send(16'h2C41, 1'b0, 1'b0);
      chk("R11 me_bit reloaded", me_bit, 0);
      chk("R11 prev_cmd reloaded", prev_cmd, 16'h2C41);

      // R3 second strobe inside the window is ignored
      @(negedge clk);
      cmd_word = 16'h2882; cmd_chan = 1'b0; cmd_vld = 1'b1;
      @(negedge clk); cmd_word = 16'h2C13;
      @(negedge clk); cmd_vld = 1'b0;
      @(negedge clk);
      chk("R3 first command result", res_vld, 1);
      chk("R3 first command kept", prev_cmd, 16'h2882);
      @(negedge clk);
      chk("R3 no second result a", res_vld, 0);
      @(negedge clk);
      chk("R3 no second result b", res_vld, 0);
      chk("R3 prev_cmd unchanged", prev_cmd, 16'h2882);

      // R2 own address 31 with broadcast off acts as normal address
      own_addr = 5'd31; bcast_en = 1'b0;
      send(16'hF882, 1'b0, 1'b0);
      chk("R2 addr31 own res_vld", res_vld, 1);
      chk("R2 addr31 own status_en", status_en, 1);
      chk("R2 addr31 own bcast", bcast, 0);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule